// File: doc/BRIEF.md
# Interval Timer Host Register Port

This block is the byte-wide register front end of a three-channel interval timer. A host reaches it through a 2-bit address: the three low addresses are data ports, one for each channel, and the highest address is a control port. Control writes set each channel's byte access mode, counting mode and BCD flag. They also freeze a channel's count and status for later reads. Data writes build 16-bit initial counts from one or two bytes. Data reads return the next byte that the channel's read sequence calls for.

The counting logic sits outside this block. Each channel gives the block its live 16-bit count and its output level. The block sends back a one-cycle load strobe with the assembled count, together with the counting mode and BCD flag it has decoded. Read data is combinational: it shows the byte that a read of the current address would return. A read takes effect, and advances the read state, at the clock edge where `rd_en` is high.

Top module: `tmr_host_if`

## Requirements
- R1: After reset every channel is in two-byte access mode (code 3) with counting mode 0 and BCD 0. No count or status is frozen, both byte toggles point at the low byte, and no load strobe is active.
- R2: A control write (address 3) whose bits 7:6 name a channel 0..2 and whose bits 5:4 are non-zero sets that channel's access mode from bits 5:4, its counting mode from bits 3:1 and its BCD flag from bit 0. The new values appear on `cfg_mode`/`cfg_bcd` after the write edge. No other write changes them.
- R3: A control write naming a channel with bits 5:4 = 00 freezes that channel's live count. Later data reads return the frozen value according to the access mode: code 1 gives the low byte, code 2 gives the high byte, and code 3 gives the low byte and then the high byte. After that, reads see the live count again.
- R4: A request to freeze the count or the status is ignored while an earlier frozen count (or status) of that channel has not been read out.
- R5: A control write with bits 7:6 = 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 at 0 freezes the count of each selected channel, and bit 4 at 0 freezes its status byte. The status byte is {OUT, 0, access mode[1:0], counting mode[2:0], BCD}, with OUT in bit 7.
- R6: A frozen status byte is returned by the next data read of its channel ahead of any frozen count, and that read clears it.
- R7: In access mode 1 a data write loads {8'h00, byte}, and in mode 2 it loads {byte, 8'h00}. `ld_stb` of that channel is high for exactly the one cycle after the write edge, with the value on its slice of `ld_val`.
- R8: In access mode 3 the first data write only holds its byte and gives no strobe. The second loads {second byte, first byte}.
- R9: With nothing frozen, data reads return the live count: the low byte in mode 1, the high byte in mode 2, and in mode 3 alternately the low byte and then the high byte.
- R10: A control write that sets a channel's access mode returns both that channel's write toggle and its read toggle to the low byte.
- R11: A read of address 3 returns 0. A data access to one channel leaves the other channels' strobes and read sequences unchanged.
- R12: `wr_en` and `rd_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle; advances the read state |
| addr | input | 2 | 0..2 channel data port, 3 control port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Byte returned by a read of `addr` |
| ch_count | input | 48 | Live 16-bit count of each channel, channel 0 in the low bits |
| ch_out | input | 3 | Output level of each channel |
| ld_stb | output | 3 | One-cycle count load pulse for each channel |
| ld_val | output | 48 | Assembled 16-bit count for each channel |
| cfg_mode | output | 9 | 3-bit counting mode for each channel |
| cfg_bcd | output | 3 | BCD flag for each channel |

## Verification
`rdata` is combinational. The bench therefore samples it in the same cycle that `rd_en` is raised, shortly after inputs change at the falling edge and before the rising edge that consumes the read. `cfg_mode`, `cfg_bcd` and `ld_stb`/`ld_val` are registered once, so the bench checks them at the falling edge that follows the write's rising edge. It checks `ld_stb` again one cycle later to confirm that the pulse lasts exactly one cycle. A value frozen by a command is checked after the bench has changed the live count, which shows that the read returns the frozen value and not the live one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_WORD = 2'd3
  } acc_e;

  typedef struct packed {
    logic cfg_we;
    logic cnt_lat;
    logic sts_lat;
    logic data_we;
    logic data_rd;
  } chan_cmd_t;
endpackage

// File: rtl/tmr_cmd_dec.sv
module tmr_cmd_dec
  import tmr_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 2
) (
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [AW-1:0]          addr,
  input  logic [BYTE_W-1:0]      wdata,
  output chan_cmd_t [NCH-1:0]    cmd
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NCH);

  logic ctrl_wr;
  logic rb_cmd;
  logic [1:0] sel;
  logic lat_fld;

  always_comb begin
    ctrl_wr = wr_en && (addr == CTRL_ADDR);
    sel     = wdata[7:6];
    rb_cmd  = (sel == 2'd3);
    lat_fld = (wdata[5:4] == 2'd0);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    logic hit;
    logic rb_sel;
    always_comb begin
      hit    = !rb_cmd && (sel == 2'(i));
      rb_sel = rb_cmd && wdata[i+1];
      cmd[i].cfg_we  = ctrl_wr && hit && !lat_fld;
      cmd[i].cnt_lat = ctrl_wr && ((hit && lat_fld) || (rb_sel && !wdata[5]));
      cmd[i].sts_lat = ctrl_wr && rb_sel && !wdata[4];
      cmd[i].data_we = wr_en && (addr == AW'(i));
      cmd[i].data_rd = rd_en && (addr == AW'(i));
    end
  end
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  chan_cmd_t         cmd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic              out_lvl,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              ld_stb,
  output logic [CNT_W-1:0]  ld_val,
  output logic [MODE_W-1:0] mode,
  output logic              bcd
);
  acc_e              acc_q, acc_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              bcd_q, bcd_d;
  logic              wr_hi_q, wr_hi_d;
  logic [BYTE_W-1:0] hold_q, hold_d;
  logic              rd_hi_q, rd_hi_d;
  acc_e              lat_q, lat_d;
  logic [CNT_W-1:0]  lat_val_q;
  logic              lat_load;
  logic              sts_pend_q, sts_pend_d;
  logic [BYTE_W-1:0] sts_val_q;
  logic              sts_load;
  logic              ld_stb_q, ld_stb_d;
  logic [CNT_W-1:0]  ld_val_q, ld_val_d;

  // byte presented to a read
  always_comb begin
    if (sts_pend_q) begin
      rd_byte = sts_val_q;
    end else if (lat_q != ACC_NONE) begin
      rd_byte = (lat_q == ACC_HI) ? lat_val_q[CNT_W-1:BYTE_W] : lat_val_q[BYTE_W-1:0];
    end else begin
      unique case (acc_q)
        ACC_HI:   rd_byte = live_cnt[CNT_W-1:BYTE_W];
        ACC_WORD: rd_byte = rd_hi_q ? live_cnt[CNT_W-1:BYTE_W] : live_cnt[BYTE_W-1:0];
        default:  rd_byte = live_cnt[BYTE_W-1:0];
      endcase
    end
  end

  // next state
  always_comb begin
    acc_d      = acc_q;
    mode_d     = mode_q;
    bcd_d      = bcd_q;
    wr_hi_d    = wr_hi_q;
    hold_d     = hold_q;
    rd_hi_d    = rd_hi_q;
    lat_d      = lat_q;
    sts_pend_d = sts_pend_q;
    ld_stb_d   = 1'b0;
    ld_val_d   = ld_val_q;
    lat_load   = 1'b0;
    sts_load   = 1'b0;

    if (cmd.data_rd) begin
      if (sts_pend_q) begin
        sts_pend_d = 1'b0;
      end else if (lat_q != ACC_NONE) begin
        lat_d = (lat_q == ACC_WORD) ? ACC_HI : ACC_NONE;
      end else if (acc_q == ACC_WORD) begin
        rd_hi_d = !rd_hi_q;
      end
    end

    if (cmd.data_we) begin
      unique case (acc_q)
        ACC_HI: begin
          ld_stb_d = 1'b1;
          ld_val_d = {wdata, {BYTE_W{1'b0}}};
        end
        ACC_WORD: begin
          if (!wr_hi_q) begin
            hold_d  = wdata;
            wr_hi_d = 1'b1;
          end else begin
            ld_stb_d = 1'b1;
            ld_val_d = {wdata, hold_q};
            wr_hi_d  = 1'b0;
          end
        end
        default: begin
          ld_stb_d = 1'b1;
          ld_val_d = {{BYTE_W{1'b0}}, wdata};
        end
      endcase
    end

    if (cmd.cfg_we) begin
      acc_d   = acc_e'(wdata[5:4]);
      mode_d  = wdata[3:1];
      bcd_d   = wdata[0];
      wr_hi_d = 1'b0;
      rd_hi_d = 1'b0;
    end

    if (cmd.cnt_lat && (lat_q == ACC_NONE)) begin
      lat_d    = acc_q;
      lat_load = 1'b1;
    end

    if (cmd.sts_lat && !sts_pend_q) begin
      sts_pend_d = 1'b1;
      sts_load   = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= ACC_WORD;
      mode_q     <= '0;
      bcd_q      <= 1'b0;
      wr_hi_q    <= 1'b0;
      hold_q     <= '0;
      rd_hi_q    <= 1'b0;
      lat_q      <= ACC_NONE;
      lat_val_q  <= '0;
      sts_pend_q <= 1'b0;
      sts_val_q  <= '0;
      ld_stb_q   <= 1'b0;
      ld_val_q   <= '0;
    end else begin
      acc_q      <= acc_d;
      mode_q     <= mode_d;
      bcd_q      <= bcd_d;
      wr_hi_q    <= wr_hi_d;
      hold_q     <= hold_d;
      rd_hi_q    <= rd_hi_d;
      lat_q      <= lat_d;
      sts_pend_q <= sts_pend_d;
      ld_stb_q   <= ld_stb_d;
      ld_val_q   <= ld_val_d;
      if (lat_load) begin
        lat_val_q <= live_cnt;
      end
      if (sts_load) begin
        sts_val_q <= {out_lvl, 1'b0, acc_q, mode_q, bcd_q};
      end
    end
  end

  assign ld_stb = ld_stb_q;
  assign ld_val = ld_val_q;
  assign mode   = mode_q;
  assign bcd    = bcd_q;
endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [1:0]            addr,
  input  logic [7:0]            wdata,
  output logic [7:0]            rdata,
  input  logic [NCH*16-1:0]     ch_count,
  input  logic [NCH-1:0]        ch_out,
  output logic [NCH-1:0]        ld_stb,
  output logic [NCH*16-1:0]     ld_val,
  output logic [NCH*3-1:0]      cfg_mode,
  output logic [NCH-1:0]        cfg_bcd
);
  localparam int AW = 2;

  chan_cmd_t [NCH-1:0] cmd;
  logic [BYTE_W-1:0]   rd_bytes [NCH];

  tmr_cmd_dec #(.NCH(NCH), .AW(AW)) u_dec (
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .cmd   (cmd)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_chan_port u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd[i]),
      .wdata    (wdata),
      .live_cnt (ch_count[i*CNT_W +: CNT_W]),
      .out_lvl  (ch_out[i]),
      .rd_byte  (rd_bytes[i]),
      .ld_stb   (ld_stb[i]),
      .ld_val   (ld_val[i*CNT_W +: CNT_W]),
      .mode     (cfg_mode[i*MODE_W +: MODE_W]),
      .bcd      (cfg_bcd[i])
    );
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(i)) begin
        rdata = rd_bytes[i];
      end
    end
  end
endmodule

// File: rtl/tmr_host_if_chk.sv
module tmr_host_if_chk #(
  parameter int NCH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [1:0]        addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic [NCH*16-1:0] ch_count,
  input logic [NCH-1:0]    ch_out,
  input logic [NCH-1:0]    ld_stb,
  input logic [NCH*16-1:0] ld_val,
  input logic [NCH*3-1:0]  cfg_mode,
  input logic [NCH-1:0]    cfg_bcd
);
  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));

  p_ctrl_rd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'(NCH)) |-> (rdata == 8'h00));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_ld_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ld_stb[i] |-> $past(wr_en && addr == 2'(i)));

    p_cfg_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'(NCH) && wdata[7:6] == 2'(i) && wdata[5:4] != 2'd0)
      |=> (cfg_mode[i*3 +: 3] == $past(wdata[3:1]) && cfg_bcd[i] == $past(wdata[0])));

    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == 2'(NCH)) |=> ($stable(cfg_mode[i*3 +: 3]) && $stable(cfg_bcd[i])));
  end
endmodule

bind tmr_host_if tmr_host_if_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/test_tmr_host_if.sv
`timescale 1ns/1ps
module test_tmr_host_if;
  localparam int NCH = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en, rd_en;
  logic [1:0]        addr;
  logic [7:0]        wdata;
  logic [7:0]        rdata;
  logic [NCH*16-1:0] ch_count;
  logic [NCH-1:0]    ch_out;
  logic [NCH-1:0]    ld_stb;
  logic [NCH*16-1:0] ld_val;
  logic [NCH*3-1:0]  cfg_mode;
  logic [NCH-1:0]    cfg_bcd;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = !clk;

  tmr_host_if #(.NCH(NCH)) i_tmr_host_if (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] b);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 b = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_live(input int c, input logic [15:0] v);
    ch_count[c*16 +: 16] = v;
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v, w;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    ch_count = '0; ch_out = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(cfg_mode == '0 && cfg_bcd == '0, "R1 cfg", int'(cfg_mode), 0);
    chk(ld_stb == '0, "R1 ld_stb", int'(ld_stb), 0);
    set_live(0, 16'hA5C3);
    rd(2'd0, b); chk(b == 8'hC3, "R1 word lo", b, 8'hC3);
    rd(2'd0, b); chk(b == 8'hA5, "R1 word hi", b, 8'hA5);

    // R11: control port reads zero
    rd(2'd3, b); chk(b == 8'h00, "R11 ctrl read", b, 0);

    // R2 sweep: every channel, access, mode, bcd
    for (int c = 0; c < NCH; c++)
      for (int a = 1; a < 4; a++)
        for (int m = 0; m < 6; m++)
          for (int z = 0; z < 2; z++) begin
            wr(2'd3, {2'(c), 2'(a), 3'(m), 1'(z)});
            chk(cfg_mode[c*3 +: 3] == 3'(m) && cfg_bcd[c] == 1'(z), "R2 cfg",
                {cfg_mode[c*3 +: 3], cfg_bcd[c]}, m*2 + z);
          end

    // R7/R8/R9/R3 per channel and access mode
    for (int c = 0; c < NCH; c++)
      for (int a = 1; a < 4; a++) begin
        v = 16'h1357 + 16'(c * 16'h2111) + 16'(a * 16'h0404);
        wr(2'd3, {2'(c), 2'(a), 3'd2, 1'b0});
        if (a == 3) begin
          wr(2'(c), v[7:0]);
          chk(ld_stb == '0, "R8 first byte no strobe", int'(ld_stb), 0);
          wr(2'(c), v[15:8]);
          chk(ld_stb == 3'(1 << c) && ld_val[c*16 +: 16] == v, "R8 word load", ld_val[c*16 +: 16], v);
        end else begin
          wr(2'(c), v[7:0]);
          w = (a == 1) ? {8'h00, v[7:0]} : {v[7:0], 8'h00};
          chk(ld_stb == 3'(1 << c) && ld_val[c*16 +: 16] == w, "R7 byte load", ld_val[c*16 +: 16], w);
        end
        @(negedge clk);
        chk(ld_stb == '0, "R7 one cycle", int'(ld_stb), 0);

        // R9 live reads
        set_live(c, v);
        rd(2'(c), b);
        w = {8'h00, (a == 2) ? v[15:8] : v[7:0]};
        chk(b == w[7:0], "R9 live first", b, w);
        if (a == 3) begin
          rd(2'(c), b); chk(b == v[15:8], "R9 live second", b, v[15:8]);
          rd(2'(c), b); chk(b == v[7:0], "R9 live wrap", b, v[7:0]);
          rd(2'(c), b); // back to low byte
        end

        // R3 freeze then change live count
        wr(2'd3, {2'(c), 2'b00, 4'h0});
        set_live(c, ~v);
        // R4: second request ignored
        wr(2'd3, {2'(c), 2'b00, 4'h0});
        rd(2'(c), b);
        w = {8'h00, (a == 2) ? v[15:8] : v[7:0]};
        chk(b == w[7:0], "R3 frozen first", b, w);
        if (a == 3) begin
          rd(2'(c), b); chk(b == v[15:8], "R4 frozen hi", b, v[15:8]);
        end
        w = ~v;
        rd(2'(c), b);
        chk(b == ((a == 2) ? w[15:8] : w[7:0]), "R3 live again", b, (a == 2) ? w[15:8] : w[7:0]);
        if (a == 3) rd(2'(c), b);
      end

    // R5/R6: read-back with status and count, channel 1
    wr(2'd3, {2'd1, 2'd3, 3'd5, 1'b1});
    set_live(1, 16'hBEEF);
    ch_out = 3'b010;
    wr(2'd3, 8'hC0 | 8'h04);
    set_live(1, 16'h0000);
    ch_out = 3'b000;
    rd(2'd1, b); chk(b == 8'hBB, "R6 status first", b, 8'hBB);
    rd(2'd1, b); chk(b == 8'hEF, "R5 rb count lo", b, 8'hEF);
    rd(2'd1, b); chk(b == 8'hBE, "R5 rb count hi", b, 8'hBE);

    // R5: status only on channel 2, out low; channel 0 untouched (R11)
    wr(2'd3, {2'd2, 2'd1, 3'd3, 1'b0});
    set_live(2, 16'h4411);
    wr(2'd3, 8'hE0 | 8'h08);
    rd(2'd2, b); chk(b == 8'h16, "R5 status only", b, 8'h16);
    rd(2'd2, b); chk(b == 8'h11, "R5 no count frozen", b, 8'h11);
    // R4: status request ignored while pending
    wr(2'd3, 8'hE0 | 8'h08);
    ch_out = 3'b100;
    wr(2'd3, 8'hE0 | 8'h08);
    rd(2'd2, b); chk(b == 8'h16, "R4 status kept", b, 8'h16);
    rd(2'd2, b); chk(b == 8'h11, "R4 status cleared", b, 8'h11);

    // R10: toggles reset by control word
    wr(2'd3, {2'd0, 2'd3, 3'd0, 1'b0});
    set_live(0, 16'h7788);
    rd(2'd0, b); // low consumed, toggle at high
    wr(2'd0, 8'h99); // write toggle at high
    wr(2'd3, {2'd0, 2'd3, 3'd0, 1'b0});
    rd(2'd0, b); chk(b == 8'h88, "R10 read toggle reset", b, 8'h88);
    rd(2'd0, b);
    wr(2'd0, 8'h12);
    chk(ld_stb == '0, "R10 write toggle reset", int'(ld_stb), 0);
    wr(2'd0, 8'h34);
    chk(ld_val[15:0] == 16'h3412 && ld_stb == 3'b001, "R10 word after reset", ld_val[15:0], 16'h3412);

    // R11: data write on channel 2 leaves channel 0 read order alone
    rd(2'd0, b); chk(b == 8'h88, "R11 isolate lo", b, 8'h88);
    wr(2'd2, 8'h55);
    chk(ld_stb == 3'b100, "R11 strobe isolation", int'(ld_stb), 4);
    rd(2'd0, b); chk(b == 8'h77, "R11 isolate hi", b, 8'h77);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule